// File: doc/BRIEF.md
# Ordered-Entry Combination Lock Controller

This block is a clocked state machine that releases a lock only after three dial operations arrive in one fixed order. Each operation has a turn direction (right or left) and a dial number. It is presented for one cycle together with a valid strobe. A two-bit progress register records how many steps in a row have been correct. The unlock output is decoded from that register alone. The values alone are not enough: entering them in any other order does not release the lock.

The default combination is right 13, then left 22, then right 3. Parameters can change it at elaboration time, but it cannot be changed at run time. A wrong operation at any point before the lock is open sends the machine back to its start. Once open, the lock stays open until the relock input or the synchronous reset is pulsed.

Top module: `seq_lock_fsm`

## Requirements
- R1: When `rst` is high at a rising edge, `stage` becomes 2'b00 and `unlocked` becomes 0, whatever the other inputs are.
- R2: `stage` encodes progress as 2'b00 (nothing correct), 2'b01 (first step done), 2'b10 (second step done) and 2'b11 (open). A valid operation moves the state forward one step when it matches the expected step. From 2'b00 the expected step is right 13, from 2'b01 it is left 22, and from 2'b10 it is right 3. Right is `op_dir`=1 and left is `op_dir`=0.
- R3: `unlocked` is 1 exactly when `stage` is 2'b11. It depends on the state only.
- R4: A valid operation in stage 2'b00, 2'b01 or 2'b10 that does not match the expected step sends `stage` to 2'b00. This applies to a wrong direction with a correct number, and to a value that would be correct for some other step.
- R5: A cycle with `op_valid` low and `relock` low leaves `stage` unchanged.
- R6: In stage 2'b11, valid operations are ignored and the lock stays open.
- R7: `relock` high at a rising edge sends `stage` to 2'b00. It takes priority over a valid operation in the same cycle.
- R8: The three correct values entered in any other order never open the lock, and the state never skips a step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One-cycle strobe qualifying a dial operation |
| op_dir | input | 1 | Turn direction, 1 = right, 0 = left |
| op_num | input | DIAL_W (6) | Dial number, 0 to DIAL_MAX (39) |
| relock | input | 1 | Returns the machine to idle |
| stage | output | 2 | Progress state register |
| unlocked | output | 1 | High when the lock is open |

## Verification
Every input takes effect at the first rising edge after it is applied. The new `stage` value, and the `unlocked` value decoded from it, can be read one cycle after the operation is driven. The bench drives each operation on a falling edge and samples both outputs at the next falling edge, half a period after the edge that registered them. Reset and relock are checked on the same one-cycle schedule, including when they share a cycle with a valid operation.

// File: rtl/seq_lock_pkg.sv
package seq_lock_pkg;
   typedef enum logic [1:0] {
      LK_IDLE = 2'b00,
      LK_GOT1 = 2'b01,
      LK_GOT2 = 2'b10,
      LK_OPEN = 2'b11
   } lock_stage_e;

   localparam int unsigned LK_STEPS = 3;
endpackage

// File: rtl/lock_step_cmp.sv
module lock_step_cmp
   import seq_lock_pkg::*;
#(
   parameter int unsigned DIAL_W = 6,
   parameter logic [LK_STEPS-1:0] STEP_DIR = 3'b101,
   parameter logic [LK_STEPS*DIAL_W-1:0] STEP_NUM = {6'd3, 6'd22, 6'd13}
) (
   input  logic              op_dir,
   input  logic [DIAL_W-1:0] op_num,
   output logic [LK_STEPS-1:0] hit
);
   for (genvar i = 0; i < LK_STEPS; i++) begin : g_step
      assign hit[i] = (op_dir == STEP_DIR[i]) &&
                      (op_num == STEP_NUM[i*DIAL_W +: DIAL_W]);
   end
endmodule

// File: rtl/lock_next_state.sv
module lock_next_state
   import seq_lock_pkg::*;
(
   input  lock_stage_e       cur,
   input  logic              op_valid,
   input  logic              relock,
   input  logic [LK_STEPS-1:0] hit,
   output lock_stage_e       nxt
);
   always_comb begin
      nxt = cur;
      if (relock) begin
         nxt = LK_IDLE;
      end else if (op_valid) begin
         unique case (cur)
            LK_IDLE: nxt = hit[0] ? LK_GOT1 : LK_IDLE;
            LK_GOT1: nxt = hit[1] ? LK_GOT2 : LK_IDLE;
            LK_GOT2: nxt = hit[2] ? LK_OPEN : LK_IDLE;
            LK_OPEN: nxt = LK_OPEN;
            default: nxt = LK_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/seq_lock_fsm.sv
module seq_lock_fsm
   import seq_lock_pkg::*;
#(
   parameter int unsigned DIAL_W   = 6,
   parameter int unsigned DIAL_MAX = 39,
   parameter logic [LK_STEPS-1:0] STEP_DIR = 3'b101,
   parameter logic [LK_STEPS*DIAL_W-1:0] STEP_NUM = {6'd3, 6'd22, 6'd13}
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              op_valid,
   input  logic              op_dir,
   input  logic [DIAL_W-1:0] op_num,
   input  logic              relock,
   output logic [1:0]        stage,
   output logic              unlocked
);
   localparam int unsigned DIAL_SPAN = 1 << DIAL_W;

   if (DIAL_W < 1 || DIAL_W > 16) begin : g_bad_width
      $error("seq_lock_fsm: DIAL_W out of range");
   end
   if (DIAL_MAX >= DIAL_SPAN) begin : g_bad_max
      $error("seq_lock_fsm: DIAL_MAX does not fit in DIAL_W bits");
   end
   for (genvar i = 0; i < LK_STEPS; i++) begin : g_chk_step
      if (int'(STEP_NUM[i*DIAL_W +: DIAL_W]) > DIAL_MAX) begin : g_bad_step
         $error("seq_lock_fsm: step number beyond dial range");
      end
   end

   logic [LK_STEPS-1:0] step_hit;
   lock_stage_e         cur_q;
   lock_stage_e         nxt_d;

   lock_step_cmp #(
      .DIAL_W  (DIAL_W),
      .STEP_DIR(STEP_DIR),
      .STEP_NUM(STEP_NUM)
   ) u_cmp (
      .op_dir(op_dir),
      .op_num(op_num),
      .hit   (step_hit)
   );

   lock_next_state u_nxt (
      .cur     (cur_q),
      .op_valid(op_valid),
      .relock  (relock),
      .hit     (step_hit),
      .nxt     (nxt_d)
   );

   always_ff @(posedge clk) begin
      if (rst) cur_q <= LK_IDLE;
      else     cur_q <= nxt_d;
   end

   assign stage    = cur_q;
   assign unlocked = (cur_q == LK_OPEN);
endmodule

// File: rtl/seq_lock_chk.sv
module seq_lock_chk (
   input logic       clk,
   input logic       rst,
   input logic       op_valid,
   input logic       relock,
   input logic [1:0] stage,
   input logic       unlocked
);
   AST_RESET_IDLE: assert property (@(posedge clk)
      rst |=> (stage == 2'b00 && !unlocked)); // R1

   AST_OPEN_NEEDS_STEP: assert property (@(posedge clk) disable iff (rst)
      $rose(unlocked) |-> ($past(stage) == 2'b10 && $past(op_valid))); // R3

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!op_valid && !relock) |=> $stable(stage)); // R5

   AST_OPEN_STICKY: assert property (@(posedge clk) disable iff (rst)
      (stage == 2'b11 && !relock) |=> (stage == 2'b11 && unlocked)); // R6

   AST_RELOCK_IDLE: assert property (@(posedge clk) disable iff (rst)
      relock |=> (stage == 2'b00)); // R7

   AST_NO_SKIP: assert property (@(posedge clk) disable iff (rst)
      (stage != 2'b11) |=> (stage == 2'b00 || stage == $past(stage) ||
                            stage == $past(stage) + 2'b01)); // R8
endmodule

bind seq_lock_fsm seq_lock_chk u_chk (
   .clk     (clk),
   .rst     (rst),
   .op_valid(op_valid),
   .relock  (relock),
   .stage   (stage),
   .unlocked(unlocked)
);

// File: tb/sim_seq_lock_fsm.sv
module sim_seq_lock_fsm;
   typedef struct packed {
      logic       rl;
      logic       v;
      logic       d;
      logic [5:0] n;
      logic [1:0] exp;
      logic [3:0] req;
   } vec_t;

   localparam int NVEC = 25;
   localparam vec_t VEC [NVEC] = '{
      '{1'b0, 1'b1, 1'b1, 6'd13, 2'd1, 4'd2},  // R2 first step
      '{1'b0, 1'b1, 1'b0, 6'd22, 2'd2, 4'd2},  // R2 second step
      '{1'b0, 1'b1, 1'b1, 6'd3,  2'd3, 4'd3},  // R3 open
      '{1'b0, 1'b1, 1'b0, 6'd5,  2'd3, 4'd6},  // R6 ignored while open
      '{1'b0, 1'b0, 1'b1, 6'd13, 2'd3, 4'd5},  // R5 no strobe
      '{1'b1, 1'b0, 1'b0, 6'd0,  2'd0, 4'd7},  // R7 relock
      '{1'b0, 1'b1, 1'b0, 6'd22, 2'd0, 4'd8},  // R8 out of order
      '{1'b0, 1'b1, 1'b1, 6'd3,  2'd0, 4'd8},  // R8 out of order
      '{1'b0, 1'b1, 1'b1, 6'd13, 2'd1, 4'd2},
      '{1'b0, 1'b0, 1'b0, 6'd22, 2'd1, 4'd5},  // R5 hold in first step
      '{1'b0, 1'b1, 1'b0, 6'd13, 2'd0, 4'd4},  // R4 wrong number
      '{1'b0, 1'b1, 1'b1, 6'd13, 2'd1, 4'd2},
      '{1'b0, 1'b1, 1'b1, 6'd22, 2'd0, 4'd4},  // R4 wrong direction
      '{1'b0, 1'b1, 1'b1, 6'd13, 2'd1, 4'd2},
      '{1'b0, 1'b1, 1'b0, 6'd22, 2'd2, 4'd2},
      '{1'b0, 1'b0, 1'b1, 6'd3,  2'd2, 4'd5},  // R5 hold in second step
      '{1'b0, 1'b1, 1'b1, 6'd13, 2'd0, 4'd4},  // R4 to idle, not step one
      '{1'b0, 1'b1, 1'b0, 6'd13, 2'd0, 4'd4},  // R4 wrong direction at idle
      '{1'b0, 1'b1, 1'b1, 6'd13, 2'd1, 4'd2},
      '{1'b0, 1'b1, 1'b0, 6'd22, 2'd2, 4'd2},
      '{1'b0, 1'b1, 1'b1, 6'd3,  2'd3, 4'd3},
      '{1'b1, 1'b1, 1'b0, 6'd22, 2'd0, 4'd7},  // R7 priority over valid op
      '{1'b0, 1'b1, 1'b1, 6'd13, 2'd1, 4'd2},
      '{1'b0, 1'b1, 1'b0, 6'd22, 2'd2, 4'd2},
      '{1'b0, 1'b1, 1'b1, 6'd3,  2'd3, 4'd3}
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       op_valid = 1'b0;
   logic       op_dir = 1'b0;
   logic [5:0] op_num = 6'd0;
   logic       relock = 1'b0;
   logic [1:0] stage;
   logic       unlocked;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   seq_lock_fsm u0 (
      .clk     (clk),
      .rst     (rst),
      .op_valid(op_valid),
      .op_dir  (op_dir),
      .op_num  (op_num),
      .relock  (relock),
      .stage   (stage),
      .unlocked(unlocked)
   );

   task automatic check(input int req, input logic [1:0] exp);
      logic exp_open;
      exp_open = (exp == 2'd3);
      checks++;
      if (stage !== exp || unlocked !== exp_open) begin
         fails++;
         $display("FAIL R%0d stage=%0d unlocked=%0b expected stage=%0d unlocked=%0b",
                  req, stage, unlocked, exp, exp_open);
      end
   endtask

   task automatic apply(input logic r, input logic rl, input logic v,
                        input logic d, input logic [5:0] n);
      rst = r; relock = rl; op_valid = v; op_dir = d; op_num = n;
      @(negedge clk);
      rst = 1'b0; relock = 1'b0; op_valid = 1'b0;
   endtask

   initial begin
      #(20000 * 10);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      apply(1'b1, 1'b0, 1'b0, 1'b0, 6'd0);
      check(1, 2'd0);                       // R1 reset state
      for (int i = 0; i < NVEC; i++) begin
         apply(1'b0, VEC[i].rl, VEC[i].v, VEC[i].d, VEC[i].n);
         check(int'(VEC[i].req), VEC[i].exp);
      end
      // R1: reset while open, with a valid op present
      apply(1'b1, 1'b0, 1'b1, 1'b1, 6'd13);
      check(1, 2'd0);
      // R1: reset from second step
      apply(1'b0, 1'b0, 1'b1, 1'b1, 6'd13);
      apply(1'b0, 1'b0, 1'b1, 1'b0, 6'd22);
      check(2, 2'd2);
      apply(1'b1, 1'b0, 1'b0, 1'b0, 6'd0);
      check(1, 2'd0);
      // R8: reversed order, then rotated order
      apply(1'b0, 1'b0, 1'b1, 1'b1, 6'd3);
      apply(1'b0, 1'b0, 1'b1, 1'b0, 6'd22);
      apply(1'b0, 1'b0, 1'b1, 1'b1, 6'd13);
      check(8, 2'd1);
      apply(1'b0, 1'b0, 1'b1, 1'b1, 6'd3);
      check(8, 2'd0);
      // R4: out-of-range dial number at idle
      apply(1'b0, 1'b0, 1'b1, 1'b1, 6'd53);
      check(4, 2'd0);
      // R5: long idle gap keeps first step
      apply(1'b0, 1'b0, 1'b1, 1'b1, 6'd13);
      repeat (5) apply(1'b0, 1'b0, 1'b0, 1'b1, 6'd3);
      check(5, 2'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule